// File: doc/BRIEF.md
# Prescaled Start/Stop Countdown Timer

This block is a memory-mapped down-counter. It has a 32-bit count and a 32-bit prescaler. Software reaches it over a simple word bus made of a chip-select, a write-enable, an 8-bit word address, 32-bit write and read data, and a ready flag. Software first writes a prescaler value and an initial count, and then writes a start command. The count then drops by one every (prescaler + 1) clock cycles. Counting ends in one of two ways: the count reaches zero, or software writes a stop command.

Start and stop act only in the run state where they make sense. While the timer counts, both value registers are locked against writes. Reading the count register while the timer counts returns the live count. Reading it while idle returns the programmed initial value. Every access completes in the cycle it is presented.

Word map (address: meaning): 0x00 command (bit 0 start, bit 1 stop, reads as zero); 0x01 state (bit 0 running, other bits zero); 0x02 prescaler value; 0x03 count value. Any other address reads as zero.

Top module: `cdtimer_top`

## Requirements
- R1: After reset the state word reads 0, and both the prescaler word and the count word read 0.
- R2: `ack` is 1 in every cycle where `sel` is 1 and 0 otherwise. A read of the command word, or of any address other than 0x00 to 0x03, returns 0.
- R3: A write to address 0x00 with bit 0 set while idle sets the running bit (state word bit 0) at the next clock edge. The live count then starts at the programmed count value, and the prescaler counter starts at the programmed prescaler value.
- R4: A start command written while running has no effect: the live count continues without a reload.
- R5: A write to address 0x00 with bit 1 set while running clears the running bit at the next edge. The same write while idle leaves the timer idle.
- R6: When bits 0 and 1 are both set in one command write, an idle timer starts and a running timer stops.
- R7: Writes to the prescaler word (0x02) are ignored while running and accepted while idle.
- R8: Writes to the count word (0x03) are ignored while running and accepted while idle.
- R9: Reading the count word returns the live count while running and the programmed initial value while idle.
- R10: With prescaler P and count T, the live count after m clock edges from the start edge equals T - floor(m/(P+1)). The live count never goes below zero. The running bit clears exactly T*(P+1)+1 edges after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Access strobe for this block |
| wr | input | 1 | 1 for a write, 0 for a read |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle where sel is 1 |
| ack | output | 1 | Access done, same cycle as sel |

## Verification
The hardest condition to reach is a write that lands in the middle of a count, at a known prescaler phase. This covers a second start, a value-register write, or a combined start/stop write. The bench keeps a free-running edge counter, notes its value at the start edge, and applies each mid-run write at a planned offset. It then predicts the live count from the elapsed edges, whether or not the write was obeyed. A sweep over small prescaler and count values also times the automatic stop to the exact edge.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;
    localparam int CMD_ADDR   = 8'h00;
    localparam int STATE_ADDR = 8'h01;
    localparam int PRE_ADDR   = 8'h02;
    localparam int CNT_ADDR   = 8'h03;

    localparam int GO_BIT     = 0;
    localparam int HALT_BIT   = 1;
    localparam int RUN_BIT    = 0;
endpackage

// File: rtl/cdtimer_decode.sv
module cdtimer_decode
    import cdtimer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        cmd_bits,
    input  logic              run,
    input  logic [DATA_W-1:0] live_cnt,
    input  logic [DATA_W-1:0] pre_cfg,
    input  logic [DATA_W-1:0] cnt_cfg,
    output logic              go_req,
    output logic              halt_req,
    output logic              pre_we,
    output logic              cnt_we,
    output logic [DATA_W-1:0] rdata,
    output logic              ack
);
    logic hit_cmd, hit_state, hit_pre, hit_cnt, wr_acc;

    always_comb begin
        hit_cmd   = (addr == ADDR_W'(CMD_ADDR));
        hit_state = (addr == ADDR_W'(STATE_ADDR));
        hit_pre   = (addr == ADDR_W'(PRE_ADDR));
        hit_cnt   = (addr == ADDR_W'(CNT_ADDR));
        wr_acc    = sel && wr;

        go_req   = wr_acc && hit_cmd && cmd_bits[GO_BIT]   && !run;
        halt_req = wr_acc && hit_cmd && cmd_bits[HALT_BIT] &&  run;
        pre_we   = wr_acc && hit_pre && !run;
        cnt_we   = wr_acc && hit_cnt && !run;

        ack   = sel;
        rdata = '0;
        if (sel && !wr) begin
            if (hit_state) rdata[RUN_BIT] = run;
            else if (hit_pre) rdata = pre_cfg;
            else if (hit_cnt) rdata = run ? live_cnt : cnt_cfg;
        end
    end
endmodule

// File: rtl/cdtimer_cfg.sv
module cdtimer_cfg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_we,
    input  logic              cnt_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pre_cfg,
    output logic [DATA_W-1:0] cnt_cfg
);
    typedef struct packed {
        logic [DATA_W-1:0] pre;
        logic [DATA_W-1:0] cnt;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (pre_we) cfg_d.pre = wdata;
        if (cnt_we) cfg_d.cnt = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign pre_cfg = cfg_q.pre;
    assign cnt_cfg = cfg_q.cnt;
endmodule

// File: rtl/cdtimer_core.sv
module cdtimer_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_req,
    input  logic              halt_req,
    input  logic [DATA_W-1:0] pre_cfg,
    input  logic [DATA_W-1:0] cnt_cfg,
    output logic              run,
    output logic [DATA_W-1:0] live_cnt
);
    typedef struct packed {
        logic              run;
        logic [DATA_W-1:0] pre;
        logic [DATA_W-1:0] cnt;
    } core_s;

    core_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (go_req) begin
            st_d.run = 1'b1;
            st_d.pre = pre_cfg;
            st_d.cnt = cnt_cfg;
        end else if (st_q.run) begin
            if (halt_req || st_q.cnt == '0) begin
                st_d.run = 1'b0;
            end else if (st_q.pre == '0) begin
                st_d.pre = pre_cfg;
                st_d.cnt = st_q.cnt - 1'b1;
            end else begin
                st_d.pre = st_q.pre - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run      = st_q.run;
    assign live_cnt = st_q.cnt;
endmodule

// File: rtl/cdtimer_top.sv
module cdtimer_top
    import cdtimer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack
);
    logic              go_req, halt_req, pre_we, cnt_we, run_w;
    logic [DATA_W-1:0] live_w, pre_w, cnt_w;

    cdtimer_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .sel(sel), .wr(wr), .addr(addr),
        .cmd_bits(wdata[HALT_BIT:GO_BIT]),
        .run(run_w), .live_cnt(live_w), .pre_cfg(pre_w), .cnt_cfg(cnt_w),
        .go_req(go_req), .halt_req(halt_req), .pre_we(pre_we), .cnt_we(cnt_we),
        .rdata(rdata), .ack(ack)
    );

    cdtimer_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .cnt_we(cnt_we),
        .wdata(wdata), .pre_cfg(pre_w), .cnt_cfg(cnt_w)
    );

    cdtimer_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .go_req(go_req), .halt_req(halt_req),
        .pre_cfg(pre_w), .cnt_cfg(cnt_w), .run(run_w), .live_cnt(live_w)
    );
endmodule

// File: rtl/cdtimer_checker.sv
module cdtimer_checker
    import cdtimer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              run,
    input logic [DATA_W-1:0] live_cnt,
    input logic [DATA_W-1:0] pre_cfg,
    input logic [DATA_W-1:0] cnt_cfg
);
    logic cmd_wr, pre_wr, cnt_wr;
    assign cmd_wr = sel && wr && (addr == ADDR_W'(CMD_ADDR));
    assign pre_wr = sel && wr && (addr == ADDR_W'(PRE_ADDR));
    assign cnt_wr = sel && wr && (addr == ADDR_W'(CNT_ADDR));

    assert_go_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[GO_BIT] && !run) |=> (run && live_cnt == $past(cnt_cfg)));

    assert_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[HALT_BIT] && run) |=> !run);

    assert_idle_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !wdata[GO_BIT] && !run) |=> !run);

    assert_pre_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_wr && run) |=> $stable(pre_cfg));

    assert_cnt_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && run) |=> $stable(cnt_cfg));

    assert_no_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (!run || live_cnt <= $past(live_cnt)));

    assert_zero_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && live_cnt == '0) |=> !run);
endmodule

bind cdtimer_top cdtimer_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .run(run_w), .live_cnt(live_w), .pre_cfg(pre_w), .cnt_cfg(cnt_w)
);

// File: tb/cdtimer_top_tb.sv
module cdtimer_top_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int t0 = 0;

    cdtimer_top u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack(ack)
    );

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic get(input logic [7:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        d = rdata;
        sel = 1'b0;
        #1;
    endtask

    function automatic logic [31:0] expect_cnt(input int t, input int p, input int m);
        int v;
        v = t - m / (p + 1);
        return (v < 0) ? 32'd0 : 32'(v);
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        get(8'h01, v); check("R1 state", v, 0);
        get(8'h02, v); check("R1 prescaler", v, 0);
        get(8'h03, v); check("R1 count", v, 0);

        // R2 ready and unmapped reads
        sel = 1'b1; addr = 8'h01; #1; check("R2 ack high", 32'(ack), 1);
        sel = 1'b0; #1; check("R2 ack low", 32'(ack), 0);
        get(8'h00, v); check("R2 command reads zero", v, 0);
        get(8'h40, v); check("R2 unmapped", v, 0);

        // R5 stop while idle
        put(8'h00, 32'h2);
        get(8'h01, v); check("R5 idle stop ignored", v, 0);

        // R3 R9 R10 sweep
        for (int p = 0; p < 4; p++) begin
            for (int t = 0; t < 5; t++) begin
                put(8'h02, 32'(p));
                put(8'h03, 32'(t));
                put(8'h00, 32'h1);
                t0 = cyc;
                get(8'h01, v); check("R3 running after start", v, 1);
                m = 0;
                while (v[0] && m < 200) begin
                    get(8'h03, v);
                    check("R10 live count", v, expect_cnt(t, p, m));
                    @(negedge clk);
                    m = cyc - t0;
                    get(8'h01, v);
                end
                check("R10 stop edge", 32'(m), 32'(t * (p + 1) + 1));
                get(8'h03, v); check("R9 idle count", v, 32'(t));
            end
        end

        // R4 R7 R8 R6 mid-run writes
        put(8'h02, 32'd3);
        put(8'h03, 32'd6);
        put(8'h00, 32'h1);
        t0 = cyc;
        repeat (5) @(negedge clk);
        put(8'h02, 32'd9);
        put(8'h03, 32'd99);
        put(8'h00, 32'h1);
        m = cyc - t0;
        get(8'h03, v); check("R4 no reload on restart", v, expect_cnt(6, 3, m));
        get(8'h02, v); check("R7 prescaler locked", v, 32'd3);
        put(8'h00, 32'h3);
        get(8'h01, v); check("R6 both bits stop running", v, 0);
        get(8'h03, v); check("R8 count locked", v, 32'd6);
        put(8'h00, 32'h3);
        get(8'h01, v); check("R6 both bits start idle", v, 1);
        get(8'h03, v); check("R3 reload on start", v, 32'd6);
        @(negedge clk);
        put(8'h00, 32'h2);
        get(8'h01, v); check("R5 stop while running", v, 0);

        // R7 R8 writes accepted while idle
        put(8'h02, 32'hA5A5_0001);
        put(8'h03, 32'h1234_5678);
        get(8'h02, v); check("R7 idle write", v, 32'hA5A5_0001);
        get(8'h03, v); check("R8 idle write", v, 32'h1234_5678);

        finish_run();
    end
endmodule